// File: doc/BRIEF.md
# Signed Word Division Unit

This block performs the signed word divide of a processor: a 32-bit signed dividend is divided by a 16-bit signed divisor taken from the low half of a 32-bit source operand. A single-cycle start pulse launches the operation. The unit then runs a shift-subtract loop on operand magnitudes, one quotient bit per step, and corrects the signs at the end. It reports its outcome with a one-cycle completion pulse that has a fixed latency.

A successful divide presents a packed word with the remainder in the upper half and the quotient in the lower half, asserts a write-enable and updates the N, Z, V and C flags. If the quotient does not fit in 16 signed bits, the flags signal overflow and the destination value passes through unchanged without a write. A zero divisor skips the arithmetic and completes early with an exception request carrying vector 5. Completion timing follows worst-case rules: a full division always takes its fixed long latency, while a trap takes the shorter trap latency.

Top module: `sdiv32x16_unit`

## Requirements
- R1: The dividend is `dividend_i` as a signed 32-bit value. The divisor is `source_i[15:0]` as a signed 16-bit value, and `source_i[31:16]` has no effect. The quotient truncates toward zero.
- R2: On success, `result_o[31:16]` holds the 16-bit remainder and `result_o[15:0]` the 16-bit quotient. `wr_en_o` pulses high together with `done_o`.
- R3: A nonzero remainder has the sign of the dividend, whatever the sign of the divisor.
- R4: On success, N equals quotient bit 15, Z is 1 exactly when the 16-bit quotient is zero, and V and C are 0.
- R5: When the true quotient lies outside -32768..32767, completion gives V=1, N=1, Z=0, C=0 and `wr_en_o`=0, and `result_o` equals the unchanged dividend.
- R6: The dividend 0x80000000 with divisor -1 (0xFFFF) is treated as an overflow with the outcome of R5.
- R7: A zero divisor completes with `trap_o`=1, `trap_vec_o`=5 and `wr_en_o`=0. `result_o` equals the dividend, and N, Z, V, C keep their previous values.
- R8: A trap completes `done_o` exactly 38 cycles after the clock edge that accepts start, and `latency_o` reads 38.
- R9: A non-trapping divide completes exactly 158 cycles after the accepting edge, and `latency_o` reads 158.
- R10: `busy_o` is high from the accepting edge until completion. A start during that time is ignored, and no second completion follows it.
- R11: `done_o` is high for exactly one cycle. `result_o` and the flags change only on a completion and hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, accepted only when idle |
| dividend_i | input | 32 | Signed dividend (destination value) |
| source_i | input | 32 | Source operand; low 16 bits are the divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Packed remainder/quotient, or unchanged dividend |
| wr_en_o | output | 1 | Destination write request, successful divide only |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag, always cleared by a divide |
| trap_o | output | 1 | Divide-by-zero exception request, with done |
| trap_vec_o | output | 8 | Exception vector number (5) |
| latency_o | output | 8 | Cycle count of the last completed operation |

## Verification
The hardest outcome to reach from the ports is a divide that reaches the sign correction with a quotient just inside or just outside the 16-bit range. This covers the most negative quotient, which still fits, and the equal positive magnitude, which does not. It also covers the case where the most negative dividend is divided by -1: the magnitude loop gives a positive 0x80000000 that only the range test catches. The stimulus picks dividends of ±32768 over ±1 and the most negative dividend over -1. A stray start pulse in the middle of a long divide shows that no second operation is launched. A trap that follows a negative-quotient divide shows that the flags are left alone.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam int DVD_W = 32;
    localparam int DVS_W = 16;
    localparam int QUO_W = 16;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TRAP = 2'd1,
        ST_DIV  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic [DVD_W-1:0] word;
        ccr_t             ccr;
        logic             ok;
    } fix_t;

    function automatic logic [DVD_W-1:0] mag_dvd(input logic [DVD_W-1:0] x);
        return x[DVD_W-1] ? (~x + 1'b1) : x;
    endfunction

    function automatic logic [DVS_W-1:0] mag_dvs(input logic [DVS_W-1:0] x);
        return x[DVS_W-1] ? (~x + 1'b1) : x;
    endfunction

    // quotient fits in QUO_W signed bits when its top bits are all equal
    function automatic logic quo_fits(input logic [DVD_W-1:0] q);
        logic [DVD_W-QUO_W:0] hi;
        hi = q[DVD_W-1:QUO_W-1];
        return (hi == '0) || (&hi);
    endfunction

endpackage

// File: rtl/sdiv_mag_core.sv
module sdiv_mag_core
    import sdiv_pkg::*;
#(
    parameter int NUM_W = DVD_W,
    parameter int DEN_W = DVS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o,
    output logic [DEN_W-1:0] rem_o,
    output logic             valid_o
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0]  num_q;
    logic [DEN_W-1:0]  den_q;
    logic [DEN_W-1:0]  rem_q;
    logic [STEP_W-1:0] step_q;
    logic              active_q;

    logic [DEN_W:0]    trial;
    logic [DEN_W:0]    diff;
    logic              take;
    logic [DEN_W-1:0]  rem_nxt;
    logic [NUM_W-1:0]  num_nxt;

    always_comb begin
        trial   = {rem_q, num_q[NUM_W-1]};
        diff    = trial - {1'b0, den_q};
        take    = ~diff[DEN_W];
        rem_nxt = take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        num_nxt = {num_q[NUM_W-2:0], take};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q    <= '0;
            den_q    <= '0;
            rem_q    <= '0;
            step_q   <= '0;
            active_q <= 1'b0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (load_i) begin
                num_q    <= num_i;
                den_q    <= den_i;
                rem_q    <= '0;
                step_q   <= '0;
                active_q <= 1'b1;
            end else if (active_q) begin
                num_q  <= num_nxt;
                rem_q  <= rem_nxt;
                step_q <= step_q + 1'b1;
                if (step_q == STEP_W'(NUM_W - 1)) begin
                    active_q <= 1'b0;
                    valid_o  <= 1'b1;
                end
            end
        end
    end

    assign quo_o = num_q;
    assign rem_o = rem_q;

    // R1
    core_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R3
    rem_below_den_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (rem_o < den_q));

endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup
    import sdiv_pkg::*;
#(
    parameter int NUM_W = DVD_W,
    parameter int DEN_W = DVS_W
) (
    input  logic [NUM_W-1:0] quo_mag_i,
    input  logic [DEN_W-1:0] rem_mag_i,
    input  logic             neg_quo_i,
    input  logic             neg_rem_i,
    output fix_t             fix_o
);
    logic [NUM_W-1:0] q_s;
    logic [DEN_W-1:0] r_s;
    logic             fits;

    always_comb begin
        q_s  = neg_quo_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
        r_s  = neg_rem_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
        fits = quo_fits(q_s);

        fix_o.ok    = fits;
        fix_o.word  = {r_s, q_s[DEN_W-1:0]};
        fix_o.ccr.c = 1'b0;
        if (fits) begin
            fix_o.ccr.n = q_s[DEN_W-1];
            fix_o.ccr.z = (q_s[DEN_W-1:0] == '0);
            fix_o.ccr.v = 1'b0;
        end else begin
            fix_o.ccr.n = 1'b1;
            fix_o.ccr.z = 1'b0;
            fix_o.ccr.v = 1'b1;
        end
    end

endmodule

// File: rtl/sdiv32x16_unit.sv
module sdiv32x16_unit
    import sdiv_pkg::*;
#(
    parameter int DIV_CYCLES  = 158,
    parameter int TRAP_CYCLES = 38,
    parameter int LAT_W       = 8,
    parameter int VEC_W       = 8,
    parameter int TRAP_VEC    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVD_W-1:0] source_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [DVD_W-1:0] result_o,
    output logic             wr_en_o,
    output logic             flag_n_o,
    output logic             flag_z_o,
    output logic             flag_v_o,
    output logic             flag_c_o,
    output logic             trap_o,
    output logic [VEC_W-1:0] trap_vec_o,
    output logic [LAT_W-1:0] latency_o
);
    localparam int CNT_W = $clog2(DIV_CYCLES + 1);

    div_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DVD_W-1:0] dvd_q;
    logic             neg_quo_q;
    logic             neg_rem_q;
    fix_t             fix_q;
    fix_t             fix_w;
    ccr_t             ccr_q;

    logic [DVS_W-1:0] dvs_w;
    logic             accept;
    logic             core_load;
    logic [DVD_W-1:0] core_quo;
    logic [DVS_W-1:0] core_rem;
    logic             core_valid;

    assign dvs_w     = source_i[DVS_W-1:0];
    assign accept    = (st_q == ST_IDLE) && start_i;
    assign core_load = accept && (dvs_w != '0);

    sdiv_mag_core #(.NUM_W(DVD_W), .DEN_W(DVS_W)) core_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (core_load),
        .num_i   (mag_dvd(dividend_i)),
        .den_i   (mag_dvs(dvs_w)),
        .quo_o   (core_quo),
        .rem_o   (core_rem),
        .valid_o (core_valid)
    );

    sdiv_fixup #(.NUM_W(DVD_W), .DEN_W(DVS_W)) fixup_i (
        .quo_mag_i (core_quo),
        .rem_mag_i (core_rem),
        .neg_quo_i (neg_quo_q),
        .neg_rem_i (neg_rem_q),
        .fix_o     (fix_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            dvd_q     <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            fix_q     <= '0;
            ccr_q     <= '0;
            done_o    <= 1'b0;
            wr_en_o   <= 1'b0;
            trap_o    <= 1'b0;
            result_o  <= '0;
            latency_o <= '0;
        end else begin
            done_o  <= 1'b0;
            wr_en_o <= 1'b0;
            trap_o  <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dvd_q     <= dividend_i;
                        neg_quo_q <= dividend_i[DVD_W-1] ^ dvs_w[DVS_W-1];
                        neg_rem_q <= dividend_i[DVD_W-1];
                        cnt_q     <= CNT_W'(1);
                        st_q      <= (dvs_w == '0) ? ST_TRAP : ST_DIV;
                    end
                end
                ST_TRAP: begin
                    if (cnt_q == CNT_W'(TRAP_CYCLES)) begin
                        done_o    <= 1'b1;
                        trap_o    <= 1'b1;
                        result_o  <= dvd_q;
                        latency_o <= LAT_W'(TRAP_CYCLES);
                        st_q      <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DIV: begin
                    if (core_valid) fix_q <= fix_w;
                    if (cnt_q == CNT_W'(DIV_CYCLES)) begin
                        done_o    <= 1'b1;
                        wr_en_o   <= fix_q.ok;
                        result_o  <= fix_q.ok ? fix_q.word : dvd_q;
                        ccr_q     <= fix_q.ccr;
                        latency_o <= LAT_W'(DIV_CYCLES);
                        st_q      <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o     = (st_q != ST_IDLE);
    assign flag_n_o   = ccr_q.n;
    assign flag_z_o   = ccr_q.z;
    assign flag_v_o   = ccr_q.v;
    assign flag_c_o   = ccr_q.c;
    assign trap_vec_o = VEC_W'(TRAP_VEC);

    // independent cycle counter used only by the latency checks
    logic [LAT_W-1:0] chk_lat_q;
    always_ff @(posedge clk) begin
        if (rst)          chk_lat_q <= '0;
        else if (accept)  chk_lat_q <= '0;
        else if (busy_o)  chk_lat_q <= chk_lat_q + 1'b1;
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    // R7
    trap_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (done_o && !wr_en_o));

    // R5
    ovf_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && flag_v_o) |-> (flag_n_o && !flag_z_o && !wr_en_o));

    // R4
    carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !trap_o) |-> !flag_c_o);

    // R8
    lat_match_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (chk_lat_q == latency_o));

    // R9
    lat_select_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (latency_o == (trap_o ? LAT_W'(TRAP_CYCLES) : LAT_W'(DIV_CYCLES))));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(dvd_q));

endmodule

// File: tb/sdiv32x16_unit_tb.sv
module sdiv32x16_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] dividend_i;
    logic [31:0] source_i;
    logic        busy_o, done_o, wr_en_o, trap_o;
    logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;
    logic [31:0] result_o;
    logic [7:0]  trap_vec_o;
    logic [7:0]  latency_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] last_ccr = 4'b0000;

    always #5 clk = ~clk;

    sdiv32x16_unit dut_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .dividend_i (dividend_i),
        .source_i   (source_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .result_o   (result_o),
        .wr_en_o    (wr_en_o),
        .flag_n_o   (flag_n_o),
        .flag_z_o   (flag_z_o),
        .flag_v_o   (flag_v_o),
        .flag_c_o   (flag_c_o),
        .trap_o     (trap_o),
        .trap_vec_o (trap_vec_o),
        .latency_o  (latency_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Launch one operation, wait for done, return the measured latency.
    task automatic launch(input logic [31:0] dvd, input logic [31:0] src,
                          output int lat);
        @(negedge clk);
        dividend_i = dvd;
        source_i   = src;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 400) begin
            @(negedge clk);
            if (!done_o) lat++;
        end
    endtask

    task automatic run_div(input logic [31:0] dvd, input logic [31:0] src,
                           input string req);
        int          lat;
        longint      a, b, q, r;
        logic [31:0] exp_res;
        logic        exp_wr, exp_trap;
        logic [3:0]  exp_ccr;
        int          exp_lat;
        logic [31:0] res_at_done;

        a = longint'($signed(dvd));
        b = longint'($signed(src[15:0]));
        if (b == 0) begin
            exp_trap = 1'b1; exp_wr = 1'b0; exp_res = dvd;
            exp_ccr  = last_ccr; exp_lat = 38;
        end else begin
            q = a / b;
            r = a % b;
            exp_trap = 1'b0; exp_lat = 158;
            if (q < -32768 || q > 32767) begin
                exp_wr = 1'b0; exp_res = dvd; exp_ccr = 4'b1010;
            end else begin
                exp_wr  = 1'b1;
                exp_res = {r[15:0], q[15:0]};
                exp_ccr = {q[15], (q[15:0] == 16'h0), 2'b00};
            end
        end

        launch(dvd, src, lat);
        check(done_o === 1'b1, req, "done seen", {63'd0, done_o}, 64'd1);
        check(lat == exp_lat, (exp_trap ? "R8" : "R9"), "latency",
              64'(lat), 64'(exp_lat));
        check(latency_o == 8'(exp_lat), (exp_trap ? "R8" : "R9"), "latency_o",
              64'(latency_o), 64'(exp_lat));
        check(result_o == exp_res, req, "result", 64'(result_o), 64'(exp_res));
        check(wr_en_o == exp_wr, req, "wr_en", 64'(wr_en_o), 64'(exp_wr));
        check(trap_o == exp_trap, "R7", "trap", 64'(trap_o), 64'(exp_trap));
        check({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == exp_ccr, req, "flags NZVC",
              64'({flag_n_o, flag_z_o, flag_v_o, flag_c_o}), 64'(exp_ccr));
        if (exp_trap)
            check(trap_vec_o == 8'd5, "R7", "vector", 64'(trap_vec_o), 64'd5);
        res_at_done = result_o;
        @(negedge clk);
        check(done_o == 1'b0 && wr_en_o == 1'b0 && trap_o == 1'b0, "R11",
              "pulse length", 64'({done_o, wr_en_o, trap_o}), 64'd0);
        check(result_o == res_at_done && busy_o == 1'b0, "R11", "hold after done",
              64'(result_o), 64'(res_at_done));
        last_ccr = exp_ccr;
    endtask

    task automatic t_reset();
        check(!done_o && !busy_o && !wr_en_o && !trap_o, "R11", "reset ctrl",
              64'({done_o, busy_o, wr_en_o, trap_o}), 64'd0);
        check(result_o == 32'd0, "R11", "reset result", 64'(result_o), 64'd0);
    endtask

    // R2 R3 R4: sign combinations
    task automatic t_signs();
        run_div(32'd100000,           32'h0000_0007, "R2");
        run_div(-32'sd100000,         32'h0000_0007, "R3");
        run_div(32'd100000,           32'h0000_FFF9, "R3");
        run_div(-32'sd100000,         32'h0000_FFF9, "R3");
        run_div(32'd5,                32'h0000_0009, "R4");
    endtask

    // R1: upper source bits have no effect
    task automatic t_upper_ignored();
        run_div(32'd100000, 32'hABCD_0007, "R1");
        check(result_o == {16'd5, 16'd14285}, "R1", "upper src ignored",
              64'(result_o), 64'({16'd5, 16'd14285}));
    endtask

    // R5 R6: range boundaries and overflow
    task automatic t_overflow();
        run_div(32'h0010_0000, 32'h0000_0001, "R5");
        run_div(32'hFFFF_8000, 32'h0000_0001, "R4");
        run_div(32'h0000_8000, 32'h0000_FFFF, "R4");
        run_div(32'h0000_8000, 32'h0000_0001, "R5");
        run_div(32'h8000_0000, 32'h0000_FFFF, "R6");
        run_div(32'h7FFF_FFFF, 32'h0000_8000, "R5");
    endtask

    // R7 R8: trap keeps flags set by a prior negative-quotient divide
    task automatic t_trap();
        run_div(-32'sd70, 32'h0000_0007, "R4");
        run_div(32'h1234_5678, 32'hFFFF_0000, "R7");
        check(flag_n_o == 1'b1, "R7", "N preserved", 64'(flag_n_o), 64'd1);
    endtask

    // R10: stray start while busy
    task automatic t_busy_ignore();
        int lat;
        int extra_done;
        @(negedge clk);
        dividend_i = 32'd1000; source_i = 32'd10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R10", "busy after accept", 64'(busy_o), 64'd1);
        repeat (10) @(negedge clk);
        dividend_i = 32'd7; source_i = 32'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 12;
        while (!done_o && lat < 400) begin
            @(negedge clk);
            if (!done_o) lat++;
        end
        check(lat == 158, "R10", "latency of first op", 64'(lat), 64'd158);
        check(result_o == {16'd0, 16'd100} && trap_o == 1'b0, "R10",
              "first op result", 64'(result_o), 64'({16'd0, 16'd100}));
        extra_done = 0;
        repeat (200) begin
            @(negedge clk);
            if (done_o) extra_done++;
        end
        check(extra_done == 0, "R10", "no second completion",
              64'(extra_done), 64'd0);
        last_ccr = 4'b0000;
    endtask

    initial begin
        start_i = 1'b0; dividend_i = '0; source_i = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_signs();
        t_upper_ignored();
        t_overflow();
        t_trap();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(1_000_000ns);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule